// File: doc/BRIEF.md
# Horizontal Line Timing Generator with Master and Slave Sync

This block produces the line timing for a digital video encoder. It runs on the pixel clock and has one horizontal sync pin that works in either direction. In master mode the block owns the pin. The first line is anchored to the release of reset. Each later line repeats from a programmed line length, and the pin is held low for a programmed sync width.

In slave mode the pin is an input. The host must pull it low at the start of every line. The block passes the pin through a synchronizer and restarts its line position from each detected falling edge. A falling edge that comes early cuts the current line short. If no edge has arrived by the end of the line, the block parks in the front porch until one does.

The block reports where each line begins and where the half-amplitude point of the analog sync edge would fall. It also reports whether the current pixel lies in the sync, active or front-porch region. These outputs let the waveform stages downstream stay aligned without counting lines themselves. Because the latencies from reset to the strobe and from the pin to the strobe are fixed, the encoder's output phase can be predicted from either anchor.

Top module: `hsync_timing_gen`

## Requirements
- R1: While `rst_n` is low and until the first line begins, `sync_out` is 1 and `line_start`, `sync_strobe`, `in_sync`, `in_active` and `in_front_porch` are 0. From the first clock after reset, `sync_oe` is 1 in master mode and 0 in slave mode.
- R2: In master mode, `sync_out` goes low and `line_start` pulses in the 18th clock cycle after the cycle in which `rst_n` was first seen high. Clock edges are counted from that first edge (edge 1).
- R3: In master mode, `sync_strobe` pulses 56 cycles after reset, which is 38 cycles after `line_start`. It repeats 38 cycles after every `line_start`.
- R4: In master mode, `line_start` repeats every `line_len` cycles, and `sync_strobe` follows the same period.
- R5: In master mode, `sync_out` and `in_sync` stay low and high respectively for exactly `sync_width` cycles from each `line_start`.
- R6: Within a running line, `in_front_porch` is high for the last FRONT_PORCH (default 16) positions of the line. `in_active` is high for the positions that fall in neither the sync region nor the front porch.
- R7: In slave mode, `sync_out` stays 1 and `sync_oe` stays 0. The pin passes through two flops. If `sync_in` is first sampled low after being high at edge e, `line_start` appears after edge e+2, which is the cycle after detection. `sync_strobe` appears after edge e+47, which is 46 cycles after detection.
- R8: In slave mode, a falling edge that arrives before `line_len` cycles have passed restarts the line at once, with the same fixed latencies as R7.
- R9: In slave mode, if no falling edge has arrived by the end of a line, the position holds. `in_front_porch` stays high and `line_start` stays low until the edge comes.
- R10: In slave mode, before the first falling edge after reset, no `line_start`, no `sync_strobe` and no region flag is raised.
- R11: The mode is captured only while `rst_n` is low. Changing `mode_slave` after reset changes neither `sync_oe` nor the master line period.
- R12: In master mode, activity on `sync_in` has no effect on `line_start` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; its release anchors the master timing |
| mode_slave | input | 1 | 1 selects slave mode, 0 selects master mode; sampled during reset |
| line_len | input | 16 | Total line length in clocks (at least 64) |
| sync_width | input | 16 | Sync pulse width in clocks (at least 1, smaller than line_len minus front porch) |
| sync_in | input | 1 | Sync pin input value (used in slave mode) |
| sync_out | output | 1 | Sync pin output value (low during sync in master mode) |
| sync_oe | output | 1 | Sync pin output enable, high in master mode only |
| line_start | output | 1 | One-cycle pulse at the first position of each line |
| sync_strobe | output | 1 | One-cycle pulse at the half-amplitude point of the sync edge |
| in_sync | output | 1 | Current position is in the sync region |
| in_active | output | 1 | Current position is between the sync region and the front porch |
| in_front_porch | output | 1 | Current position is in the front porch |

## Verification
The line position counter is the only real state. A wrong value there shows at the ports within one line: `line_start` lands on the wrong cycle, or the sync, active and front-porch flags split the line in the wrong proportions. A boot counter that is off by one moves both the pin fall and the strobe by that amount in the very first line. A synchronizer with the wrong depth, or a mishandled restart or hold, shifts the slave `line_start` and strobe by whole cycles relative to the host's edge. The directed scenarios therefore compare exact cycle indices against each anchor. They also count how many cycles each flag is high.

// File: rtl/hts_pkg.sv
package hts_pkg;

   // Line controller states
   typedef enum logic [1:0] {
      HTS_BOOT = 2'd0,   // master: waiting out the reset-to-pin latency
      HTS_WAIT = 2'd1,   // slave: waiting for the first host edge
      HTS_RUN  = 2'd2    // a line is in progress
   } hts_state_e;

   // Default latencies, all in pixel clocks
   localparam int HTS_DEF_PIN_LAT      = 18;
   localparam int HTS_DEF_M_STROBE_LAT = 56;
   localparam int HTS_DEF_S_STROBE_LAT = 46;
   localparam int HTS_DEF_FRONT_PORCH  = 16;
   localparam int HTS_DEF_LEN_W        = 16;
   localparam int HTS_DEF_SYNC_STAGES  = 2;

endpackage

// File: rtl/hts_pin_sync.sv
module hts_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hts_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   // sh[STAGES-1] is the synchronized pin; sh[STAGES] is its previous value
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], pin};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];

   // R7
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/hts_boot.sv
module hts_boot #(
   parameter int PIN_LAT = 18
) (
   input  logic clk,
   input  logic rst_n,
   output logic fire
);

   localparam int CW = $clog2(PIN_LAT + 1);
   localparam logic [CW-1:0] FIRE_AT = CW'(PIN_LAT - 1);
   localparam logic [CW-1:0] SAT_AT  = CW'(PIN_LAT);

   generate
      if (PIN_LAT < 2) begin : g_bad_lat
         $error("hts_boot: PIN_LAT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (cnt != SAT_AT) cnt <= cnt + 1'b1;
   end

   assign fire = (cnt == FIRE_AT);

   // R2
   boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/hts_line_ctr.sv
module hts_line_ctr
   import hts_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_raw,
   input  logic             slave,
   input  logic             boot_fire,
   input  logic             pin_fall,
   input  logic [LEN_W-1:0] line_len,
   output hts_state_e       state,
   output logic [LEN_W-1:0] pos
);

   logic [LEN_W-1:0] last_pos;
   logic             at_end;

   assign last_pos = line_len - LEN_W'(1);
   assign at_end   = (pos >= last_pos);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= mode_raw ? HTS_WAIT : HTS_BOOT;
         pos   <= '0;
      end else begin
         unique case (state)
            HTS_BOOT: begin
               if (boot_fire) begin
                  state <= HTS_RUN;
                  pos   <= '0;
               end
            end
            HTS_WAIT: begin
               if (pin_fall) begin
                  state <= HTS_RUN;
                  pos   <= '0;
               end
            end
            HTS_RUN: begin
               if (slave && pin_fall) pos <= '0;
               else if (at_end)       pos <= slave ? pos : '0;
               else                   pos <= pos + 1'b1;
            end
            default: begin
               state <= HTS_BOOT;
               pos   <= '0;
            end
         endcase
      end
   end

   // R8
   slave_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HTS_RUN && slave && pin_fall) |=> (pos == '0));

   // R9
   slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HTS_RUN && slave && !pin_fall && at_end) |=> (pos == $past(pos)));

   // R4
   master_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == HTS_RUN && !slave && at_end) |=> (pos == '0));

endmodule

// File: rtl/hts_decode.sv
module hts_decode
   import hts_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int FRONT_PORCH   = 16,
   parameter int M_STROBE_POS  = 38,
   parameter int S_STROBE_POS  = 45
) (
   input  hts_state_e       state,
   input  logic             slave,
   input  logic [LEN_W-1:0] pos,
   input  logic [LEN_W-1:0] line_len,
   input  logic [LEN_W-1:0] sync_width,
   output logic             line_start,
   output logic             sync_strobe,
   output logic             in_sync,
   output logic             in_active,
   output logic             in_front_porch
);

   localparam logic [LEN_W-1:0] FP_LEN = LEN_W'(FRONT_PORCH);
   localparam logic [LEN_W-1:0] M_POS  = LEN_W'(M_STROBE_POS);
   localparam logic [LEN_W-1:0] S_POS  = LEN_W'(S_STROBE_POS);

   logic             running;
   logic [LEN_W-1:0] fp_begin;
   logic [LEN_W-1:0] strobe_pos;

   assign running    = (state == HTS_RUN);
   assign fp_begin   = line_len - FP_LEN;
   assign strobe_pos = slave ? S_POS : M_POS;

   always_comb begin
      line_start     = running && (pos == '0);
      sync_strobe    = running && (pos == strobe_pos);
      in_sync        = running && (pos < sync_width);
      in_front_porch = running && !in_sync && (pos >= fp_begin);
      in_active      = running && !in_sync && !in_front_porch;
   end

endmodule

// File: rtl/hsync_timing_gen.sv
module hsync_timing_gen
   import hts_pkg::*;
#(
   parameter int LEN_W         = HTS_DEF_LEN_W,
   parameter int SYNC_STAGES   = HTS_DEF_SYNC_STAGES,
   parameter int FRONT_PORCH   = HTS_DEF_FRONT_PORCH,
   parameter int PIN_LAT       = HTS_DEF_PIN_LAT,
   parameter int M_STROBE_LAT  = HTS_DEF_M_STROBE_LAT,
   parameter int S_STROBE_LAT  = HTS_DEF_S_STROBE_LAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_slave,
   input  logic [LEN_W-1:0] line_len,
   input  logic [LEN_W-1:0] sync_width,
   input  logic             sync_in,
   output logic             sync_out,
   output logic             sync_oe,
   output logic             line_start,
   output logic             sync_strobe,
   output logic             in_sync,
   output logic             in_active,
   output logic             in_front_porch
);

   localparam int M_STROBE_POS = M_STROBE_LAT - PIN_LAT;
   localparam int S_STROBE_POS = S_STROBE_LAT - 1;

   generate
      if (M_STROBE_LAT <= PIN_LAT) begin : g_bad_master
         $error("hsync_timing_gen: master strobe must follow the pin fall");
      end
      if (S_STROBE_LAT < 2) begin : g_bad_slave
         $error("hsync_timing_gen: slave strobe latency too small");
      end
      if (FRONT_PORCH < 1 || FRONT_PORCH >= (1 << LEN_W)) begin : g_bad_fp
         $error("hsync_timing_gen: FRONT_PORCH out of range");
      end
   endgenerate

   logic       mode_q;
   logic       boot_fire;
   logic       pin_fall;
   hts_state_e state;
   logic [LEN_W-1:0] pos;

   // mode captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= mode_slave;
   end

   hts_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sync_in),
      .fall  (pin_fall)
   );

   hts_boot #(.PIN_LAT(PIN_LAT)) u_boot (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (boot_fire)
   );

   hts_line_ctr #(.LEN_W(LEN_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_raw  (mode_slave),
      .slave     (mode_q),
      .boot_fire (boot_fire),
      .pin_fall  (pin_fall),
      .line_len  (line_len),
      .state     (state),
      .pos       (pos)
   );

   hts_decode #(
      .LEN_W        (LEN_W),
      .FRONT_PORCH  (FRONT_PORCH),
      .M_STROBE_POS (M_STROBE_POS),
      .S_STROBE_POS (S_STROBE_POS)
   ) u_dec (
      .state          (state),
      .slave          (mode_q),
      .pos            (pos),
      .line_len       (line_len),
      .sync_width     (sync_width),
      .line_start     (line_start),
      .sync_strobe    (sync_strobe),
      .in_sync        (in_sync),
      .in_active      (in_active),
      .in_front_porch (in_front_porch)
   );

   assign sync_oe  = !mode_q;
   assign sync_out = !(sync_oe && in_sync);

   // R3
   strobe_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({line_start, sync_strobe}));

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(sync_oe));

   // R5
   start_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && sync_width != '0) |-> in_sync);

endmodule

// File: tb/hsync_timing_gen_test.sv
module hsync_timing_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_slave = 1'b0;
   logic [15:0] line_len = 16'd100;
   logic [15:0] sync_width = 16'd10;
   logic        sync_in = 1'b1;
   logic        sync_out, sync_oe, line_start, sync_strobe;
   logic        in_sync, in_active, in_front_porch;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   hsync_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave),
      .line_len(line_len), .sync_width(sync_width), .sync_in(sync_in),
      .sync_out(sync_out), .sync_oe(sync_oe), .line_start(line_start),
      .sync_strobe(sync_strobe), .in_sync(in_sync), .in_active(in_active),
      .in_front_porch(in_front_porch)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(input logic slave);
      rst_n = 1'b0;
      mode_slave = slave;
      sync_in = 1'b1;
      step; step; step;
      // R1 reset state
      chk("R1 sync_out in reset", sync_out, 1);
      chk("R1 flags in reset",
          int'({line_start, sync_strobe, in_sync, in_active, in_front_porch}), 0);
      chk("R1 sync_oe by mode", sync_oe, slave ? 0 : 1);
      rst_n = 1'b1;
   endtask

   task automatic test_master_boot;
      int fall_k = -1, ls_k = -1, st_k = -1, early = 0;
      line_len = 16'd100; sync_width = 16'd10;
      do_reset(1'b0);
      for (int k = 1; k <= 60; k++) begin
         step;
         if (!sync_out && fall_k < 0) fall_k = k;
         if (line_start && ls_k < 0) ls_k = k;
         if (sync_strobe && st_k < 0) st_k = k;
         if (k < 18 && (line_start || in_sync || in_active || in_front_porch || !sync_out))
            early++;
      end
      chk("R1 quiet during boot", early, 0);
      chk("R2 pin fall cycle", fall_k, 18);
      chk("R2 first line_start cycle", ls_k, 18);
      chk("R3 first strobe cycle", st_k, 56);
   endtask

   task automatic test_master_period;
      int ls2 = -1, st2 = -1, nls = 0, low = 0, syn = 0, fp = 0, act = 0, fp_first = -1;
      line_len = 16'd100; sync_width = 16'd10;
      do_reset(1'b0);
      for (int k = 1; k <= 230; k++) begin
         step;
         if (line_start) begin
            nls++;
            if (k > 18 && ls2 < 0) ls2 = k;
         end
         if (sync_strobe && k > 56 && st2 < 0) st2 = k;
         if (k >= 118 && k < 218) begin
            if (!sync_out) low++;
            if (in_sync) syn++;
            if (in_front_porch) begin
               fp++;
               if (fp_first < 0) fp_first = k;
            end
            if (in_active) act++;
         end
      end
      chk("R4 second line_start", ls2, 118);
      chk("R4 line_start count", nls, 3);
      chk("R3 second strobe", st2, 156);
      chk("R5 pin low cycles", low, 10);
      chk("R5 in_sync cycles", syn, 10);
      chk("R6 front porch cycles", fp, 16);
      chk("R6 front porch start", fp_first, 202);
      chk("R6 active cycles", act, 74);
   endtask

   task automatic test_master_ignores_pin;
      int hits = 0, nls = 0;
      line_len = 16'd64; sync_width = 16'd8;
      do_reset(1'b0);
      for (int k = 1; k <= 160; k++) begin
         step;
         if (line_start) begin
            nls++;
            if (k == 18 || k == 82 || k == 146) hits++;
         end
         sync_in = ((k % 7) == 3) ? 1'b0 : 1'b1;
      end
      sync_in = 1'b1;
      chk("R12 line_start on schedule", hits, 3);
      chk("R12 line_start count", nls, 3);
   endtask

   task automatic test_mode_latch;
      int oe_bad = 0, hits = 0;
      line_len = 16'd64; sync_width = 16'd8;
      do_reset(1'b0);
      mode_slave = 1'b1;
      for (int k = 1; k <= 100; k++) begin
         step;
         if (!sync_oe) oe_bad++;
         if (line_start && (k == 18 || k == 82)) hits++;
      end
      chk("R11 sync_oe kept after mode change", oe_bad, 0);
      chk("R11 master period kept", hits, 2);
      do_reset(1'b1);
      step;
      chk("R11 slave taken at reset", sync_oe, 0);
   endtask

   task automatic test_slave_basic;
      int noise = 0, ls_j = -1, st_j = -1, drv = 0;
      line_len = 16'd100; sync_width = 16'd10;
      do_reset(1'b1);
      for (int k = 1; k <= 20; k++) begin
         step;
         if (line_start || sync_strobe || in_sync || in_active || in_front_porch) noise++;
         if (sync_oe || !sync_out) drv++;
      end
      chk("R10 nothing before first edge", noise, 0);
      chk("R7 pin not driven", drv, 0);
      sync_in = 1'b0;
      for (int j = 1; j <= 60; j++) begin
         step;
         if (j == 4) sync_in = 1'b1;
         if (line_start && ls_j < 0) ls_j = j;
         if (sync_strobe && st_j < 0) st_j = j;
         if (sync_oe || !sync_out) drv++;
      end
      chk("R7 slave line_start", ls_j, 3);
      chk("R7 slave strobe", st_j, 48);
      chk("R7 pin stays undriven", drv, 0);
   endtask

   task automatic test_slave_early;
      int ls_a = 0, ls_b = 0, nls = 0, st_b = 0, fp = 0;
      line_len = 16'd200; sync_width = 16'd10;
      do_reset(1'b1);
      step;
      sync_in = 1'b0;
      for (int j = 1; j <= 300; j++) begin
         step;
         if (j == 4) sync_in = 1'b1;
         if (j == 100) sync_in = 1'b0;
         if (j == 104) sync_in = 1'b1;
         if (line_start) begin
            nls++;
            if (j == 3) ls_a++;
            if (j == 103) ls_b++;
         end
         if (sync_strobe && j == 148) st_b++;
         if (j < 103 && in_front_porch) fp++;
      end
      chk("R8 first line_start", ls_a, 1);
      chk("R8 early restart line_start", ls_b, 1);
      chk("R8 early restart strobe", st_b, 1);
      chk("R8 line_start count", nls, 2);
      chk("R8 no front porch before restart", fp, 0);
   endtask

   task automatic test_slave_late;
      int fp = 0, ls_mid = 0, ls_b = -1, st_b = -1;
      line_len = 16'd80; sync_width = 16'd10;
      do_reset(1'b1);
      step;
      sync_in = 1'b0;
      for (int j = 1; j <= 210; j++) begin
         step;
         if (j == 4) sync_in = 1'b1;
         if (j == 150) sync_in = 1'b0;
         if (j == 154) sync_in = 1'b1;
         if (j >= 67 && j <= 152 && in_front_porch) fp++;
         if (j > 3 && j < 153 && line_start) ls_mid++;
         if (j >= 153 && line_start && ls_b < 0) ls_b = j;
         if (j > 48 && sync_strobe && st_b < 0) st_b = j;
      end
      chk("R9 front porch held", fp, 86);
      chk("R9 no line_start while late", ls_mid, 0);
      chk("R9 late line_start", ls_b, 153);
      chk("R9 late strobe", st_b, 198);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      test_master_boot;
      test_master_period;
      test_master_ignores_pin;
      test_mode_latch;
      test_slave_basic;
      test_slave_early;
      test_slave_late;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule